// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Requests

This block keeps the status flags of a serial port that handles LIN traffic, and turns them into two interrupt lines. The receiver and transmitter datapaths send it one-cycle event pulses. These pulses report a completed byte, a framing error, a parity error, a detected break, a transmit register handed to the shift register, and the start of an idle period on either direction. The CPU side sends single-cycle strobes for reading receive data, writing transmit data and writing a control word.

The control word holds the interrupt enables, the receive FIFO enable and a trigger-level selector. It also carries two action bits: one clears the receive errors, and one writes the break flag. A small fill counter tracks how many received bytes are waiting. When the FIFO is off, that counter behaves as a one-entry register. The receive-ready flag follows the counter against the selected trigger level. The reception interrupt combines the receive flags, the break flag and the idle flags under their own enables. The transmission interrupt follows the transmit-empty flag.

Control word layout (`wr_data_i` / `ctl_rd_o`):

- bit 0: receive interrupt enable
- bit 1: transmit interrupt enable
- bit 2: break interrupt enable
- bit 3: idle interrupt enable
- bit 4: FIFO enable
- bits 6:5: trigger select
- bit 7: clear-errors action
- bit 8: break flag

Top module: `sio_flag_ctrl`

## Requirements
- R1: After reset, every flag, both interrupt outputs, the stored control bits and the fill level are 0, except transmit-empty, which is 1.
- R2: The receive-ready flag is 1 exactly when the fill level is at or above the threshold. The threshold is 1 with the FIFO off. With the FIFO on, trigger select 0, 1, 2 and 3 give 1, 4, 8 and 14 entries. A `rd_rxd_i` strobe lowers the level by one, and does nothing when the level is 0.
- R3: A byte that completes while the store is full drops the byte and sets the overrun flag, with the level unchanged. The store is full at 1 entry with the FIFO off and at 16 with it on. A read in the same cycle frees room, and then the byte is accepted.
- R4: A control write with bit 7 = 1 clears overrun, framing error and parity error together. A write with bit 7 = 0 leaves them alone, and bit 7 always reads back as 0.
- R5: A framing-error or parity-error pulse sets its own flag on the next clock edge.
- R6: A break pulse sets the break flag. A control write with bit 8 = 0 clears it, a write with bit 8 = 1 leaves it unchanged, and `ctl_rd_o[8]` shows the flag.
- R7: A transmit-load pulse sets transmit-empty and `wr_txd_i` clears it. `tx_irq_o` is the registered AND of bit 1 and transmit-empty, one cycle after the flag.
- R8: Receive-idle and transmit-idle pulses set their flags. A completed received byte clears receive-idle, and a transmit load clears transmit-idle. Both feed the reception interrupt under bit 3.
- R9: When a flag's set event and clear event fall in the same cycle, the flag ends at 1.
- R10: `rx_irq_o` is registered. It is 1 one cycle after any of these holds:
  - bit 0 and one of ready, overrun, framing error or parity error
  - bit 2 and break
  - bit 3 and either idle flag
- R11: A control write that changes bit 4 empties the fill level to 0. This discards any byte completing in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done_i | input | 1 | Received byte completed (pulse) |
| rx_frame_err_i | input | 1 | Framing error (pulse) |
| rx_par_err_i | input | 1 | Parity error (pulse) |
| rx_brk_i | input | 1 | Break detected (pulse) |
| tx_load_i | input | 1 | Transmit data moved to the shift register (pulse) |
| rx_idle_i | input | 1 | Receive line went idle (pulse) |
| tx_idle_i | input | 1 | Transmit line went idle (pulse) |
| rd_rxd_i | input | 1 | CPU read of receive data |
| wr_txd_i | input | 1 | CPU write of transmit data |
| wr_ctl_i | input | 1 | CPU control-word write |
| wr_data_i | input | 9 | Control-word write data |
| rx_irq_o | output | 1 | Reception interrupt request |
| tx_irq_o | output | 1 | Transmission interrupt request |
| rdy_o | output | 1 | Receive-ready flag |
| ovr_o | output | 1 | Overrun flag |
| fer_o | output | 1 | Framing-error flag |
| per_o | output | 1 | Parity-error flag |
| brk_o | output | 1 | Break flag |
| txe_o | output | 1 | Transmit-empty flag |
| tx_idle_o | output | 1 | Transmit-idle flag |
| rx_idle_o | output | 1 | Receive-idle flag |
| ctl_rd_o | output | 9 | Control-word read-back |
| lvl_o | output | 5 | Receive fill level |

## Verification
The bench aims at the collisions between set and clear events: an error pulse during an error-clear write, a break during a break-clearing write, and a load during a transmit write. A design that let the clear win would lose an event there. It fills the store to exactly its capacity in both FIFO modes and pushes one more byte. A design with an off-by-one capacity or a counting overflow would either miss the overrun or wrap the level. Each trigger level is walked up and back down. A threshold compared with the wrong operator, or taken from the stale control word, shows up as receive-ready moving one byte early or late. The bench also writes the action bits as 0, where a design that treated them as levels would wrongly clear the errors or the break flag.

// File: rtl/sio_flag_pkg.sv
package sio_flag_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'd0,
    TRIG_FOUR = 2'd1,
    TRIG_EIGHT = 2'd2,
    TRIG_FOURTEEN = 2'd3
  } trig_sel_e;

  // Control word, LSB is the last member
  typedef struct packed {
    logic      brk_wr;
    logic      clr_err;
    trig_sel_e trig;
    logic      fifo_en;
    logic      idle_ie;
    logic      brk_ie;
    logic      tx_ie;
    logic      rx_ie;
  } ctl_word_t;

  localparam int CTL_W  = $bits(ctl_word_t);
  localparam int KEEP_W = 7;   // bits held in the control register

  // Flag cell indices
  localparam int F_OVR   = 0;
  localparam int F_FER   = 1;
  localparam int F_PER   = 2;
  localparam int F_BRK   = 3;
  localparam int F_TXE   = 4;
  localparam int F_TIDLE = 5;
  localparam int F_RIDLE = 6;
  localparam int NFLAG   = 7;

  function automatic int unsigned trig_level(trig_sel_e s);
    case (s)
      TRIG_ONE:   return 1;
      TRIG_FOUR:  return 4;
      TRIG_EIGHT: return 8;
      default:    return 14;
    endcase
  endfunction

endpackage

// File: rtl/sio_flag_cell.sv
module sio_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_d, q_q;

  // set has priority so no event is lost
  always_comb begin
    q_d = q_q;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST_VAL;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  assert_clear_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));

endmodule

// File: rtl/sio_rx_level.sv
module sio_rx_level
  import sio_flag_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int W = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push_i,
  input  logic      pop_i,
  input  logic      flush_i,
  input  logic      cap_en_i,    // FIFO enable in force this cycle
  input  logic      thr_en_i,    // FIFO enable after this cycle
  input  trig_sel_e thr_sel_i,   // trigger select after this cycle
  output logic [W-1:0] lvl_o,
  output logic      rdy_o,
  output logic      drop_o
);

  logic [W-1:0] lvl_q, lvl_d, cap, thr;
  logic         full, take, give, rdy_d, rdy_q;

  always_comb begin
    cap    = cap_en_i ? W'(DEPTH) : W'(1);
    full   = (lvl_q == cap);
    give   = pop_i && (lvl_q != '0);
    take   = push_i && (!full || pop_i);
    drop_o = push_i && full && !pop_i;
    thr    = thr_en_i ? W'(trig_level(thr_sel_i)) : W'(1);
    if (flush_i) begin
      lvl_d = '0;
    end else begin
      case ({take, give})
        2'b10:   lvl_d = lvl_q + W'(1);
        2'b01:   lvl_d = lvl_q - W'(1);
        default: lvl_d = lvl_q;
      endcase
    end
    rdy_d = (lvl_d >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      rdy_q <= rdy_d;
    end
  end

  assign lvl_o = lvl_q;
  assign rdy_o = rdy_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q <= W'(DEPTH)) && (cap_en_i || lvl_q <= W'(1)));

  assert_drop_keeps_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_o && !flush_i) |=> (lvl_q == $past(lvl_q)));

  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (lvl_q == '0));

endmodule

// File: rtl/sio_irq_gen.sv
module sio_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_ie_i,
  input  logic tx_ie_i,
  input  logic brk_ie_i,
  input  logic idle_ie_i,
  input  logic rdy_i,
  input  logic ovr_i,
  input  logic fer_i,
  input  logic per_i,
  input  logic brk_i,
  input  logic txe_i,
  input  logic tidle_i,
  input  logic ridle_i,
  output logic rx_irq_o,
  output logic tx_irq_o
);

  logic rx_d, tx_d, rx_q, tx_q;

  always_comb begin
    rx_d = (rx_ie_i && (rdy_i || ovr_i || fer_i || per_i))
         || (brk_ie_i && brk_i)
         || (idle_ie_i && (tidle_i || ridle_i));
    tx_d = tx_ie_i && txe_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= rx_d;
      tx_q <= tx_d;
    end
  end

  assign rx_irq_o = rx_q;
  assign tx_irq_o = tx_q;

  assert_tx_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_o |-> $past(tx_ie_i));

  assert_rx_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |-> $past(rx_ie_i || brk_ie_i || idle_ie_i));

endmodule

// File: rtl/sio_flag_ctrl.sv
module sio_flag_ctrl
  import sio_flag_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_done_i,
  input  logic       rx_frame_err_i,
  input  logic       rx_par_err_i,
  input  logic       rx_brk_i,
  input  logic       tx_load_i,
  input  logic       rx_idle_i,
  input  logic       tx_idle_i,
  input  logic       rd_rxd_i,
  input  logic       wr_txd_i,
  input  logic       wr_ctl_i,
  input  logic [8:0] wr_data_i,
  output logic       rx_irq_o,
  output logic       tx_irq_o,
  output logic       rdy_o,
  output logic       ovr_o,
  output logic       fer_o,
  output logic       per_o,
  output logic       brk_o,
  output logic       txe_o,
  output logic       tx_idle_o,
  output logic       rx_idle_o,
  output logic [8:0] ctl_rd_o,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] lvl_o
);

  localparam logic [NFLAG-1:0] FLAG_RST = NFLAG'(1) << F_TXE;

  logic [KEEP_W-1:0] ctl_q, ctl_d;
  ctl_word_t         wf, cur, nxt;
  logic              flush, clr_err, brk_clr, drop;
  logic [NFLAG-1:0]  f_set, f_clr, f_q;

  // control register: next state
  always_comb begin
    wf    = ctl_word_t'(wr_data_i);
    ctl_d = wr_ctl_i ? wr_data_i[KEEP_W-1:0] : ctl_q;
    cur   = ctl_word_t'({{(CTL_W-KEEP_W){1'b0}}, ctl_q});
    nxt   = ctl_word_t'({{(CTL_W-KEEP_W){1'b0}}, ctl_d});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= '0;
    else if (wr_ctl_i) ctl_q <= ctl_d;
  end

  // write-derived actions
  always_comb begin
    flush   = wr_ctl_i && (wf.fifo_en != cur.fifo_en);
    clr_err = wr_ctl_i && wf.clr_err;
    brk_clr = wr_ctl_i && !wf.brk_wr;
  end

  sio_rx_level #(.DEPTH(FIFO_DEPTH)) i_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (rx_done_i),
    .pop_i     (rd_rxd_i),
    .flush_i   (flush),
    .cap_en_i  (cur.fifo_en),
    .thr_en_i  (nxt.fifo_en),
    .thr_sel_i (nxt.trig),
    .lvl_o     (lvl_o),
    .rdy_o     (rdy_o),
    .drop_o    (drop)
  );

  // flag events
  always_comb begin
    f_set          = '0;
    f_clr          = '0;
    f_set[F_OVR]   = drop;
    f_set[F_FER]   = rx_frame_err_i;
    f_set[F_PER]   = rx_par_err_i;
    f_set[F_BRK]   = rx_brk_i;
    f_set[F_TXE]   = tx_load_i;
    f_set[F_TIDLE] = tx_idle_i;
    f_set[F_RIDLE] = rx_idle_i;
    f_clr[F_OVR]   = clr_err;
    f_clr[F_FER]   = clr_err;
    f_clr[F_PER]   = clr_err;
    f_clr[F_BRK]   = brk_clr;
    f_clr[F_TXE]   = wr_txd_i;
    f_clr[F_TIDLE] = tx_load_i;
    f_clr[F_RIDLE] = rx_done_i;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sio_flag_cell #(.RST_VAL(FLAG_RST[g])) i_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (f_set[g]),
      .clr_i (f_clr[g]),
      .q_o   (f_q[g])
    );
  end

  assign ovr_o     = f_q[F_OVR];
  assign fer_o     = f_q[F_FER];
  assign per_o     = f_q[F_PER];
  assign brk_o     = f_q[F_BRK];
  assign txe_o     = f_q[F_TXE];
  assign tx_idle_o = f_q[F_TIDLE];
  assign rx_idle_o = f_q[F_RIDLE];

  sio_irq_gen i_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_ie_i   (cur.rx_ie),
    .tx_ie_i   (cur.tx_ie),
    .brk_ie_i  (cur.brk_ie),
    .idle_ie_i (cur.idle_ie),
    .rdy_i     (rdy_o),
    .ovr_i     (ovr_o),
    .fer_i     (fer_o),
    .per_i     (per_o),
    .brk_i     (brk_o),
    .txe_i     (txe_o),
    .tidle_i   (tx_idle_o),
    .ridle_i   (rx_idle_o),
    .rx_irq_o  (rx_irq_o),
    .tx_irq_o  (tx_irq_o)
  );

  // read-back: action bit 7 reads 0, bit 8 shows the break flag
  assign ctl_rd_o = {brk_o, 1'b0, ctl_q};

  assert_rx_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq_o |-> $past(rdy_o || ovr_o || fer_o || per_o || brk_o || tx_idle_o || rx_idle_o));

  assert_tx_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_o |-> $past(txe_o));

  assert_err_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl_i && wr_data_i[7] && !rx_frame_err_i && !rx_par_err_i) |=> (!fer_o && !per_o));

  assert_txe_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd_i && !tx_load_i) |=> !txe_o);

  assert_brk_write_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_o && wr_ctl_i && wr_data_i[8]) |=> brk_o);

  assert_ready_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && !cur.fifo_en && !wr_ctl_i && !rd_rxd_i) |=> rdy_o);

endmodule

// File: tb/test_sio_flag_ctrl.sv
module test_sio_flag_ctrl;

  logic clk;
  logic rst_n;
  logic rx_done, rx_ferr, rx_perr, rx_brk, tx_load, rx_idle, tx_idle;
  logic rd_rxd, wr_txd, wr_ctl;
  logic [8:0] wr_data;
  logic rx_irq, tx_irq, rdy, ovr, fer, per, brk, txe, tidle, ridle;
  logic [8:0] ctl_rd;
  logic [4:0] lvl;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sio_flag_ctrl #(.FIFO_DEPTH(16)) i_sio_flag_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rx_done_i(rx_done), .rx_frame_err_i(rx_ferr), .rx_par_err_i(rx_perr),
    .rx_brk_i(rx_brk), .tx_load_i(tx_load), .rx_idle_i(rx_idle), .tx_idle_i(tx_idle),
    .rd_rxd_i(rd_rxd), .wr_txd_i(wr_txd), .wr_ctl_i(wr_ctl), .wr_data_i(wr_data),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .rdy_o(rdy), .ovr_o(ovr), .fer_o(fer),
    .per_o(per), .brk_o(brk), .txe_o(txe), .tx_idle_o(tidle), .rx_idle_o(ridle),
    .ctl_rd_o(ctl_rd), .lvl_o(lvl)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] q_exp[$];
  string       q_tag[$];

  // reference model state
  int         m_lvl;
  logic       m_rdy, m_ovr, m_fer, m_per, m_brk, m_txe, m_tidle, m_ridle, m_rxi, m_txi;
  logic [6:0] m_ctl;

  function automatic logic [23:0] dut_snap();
    return {rx_irq, tx_irq, rdy, ovr, fer, per, brk, txe, tidle, ridle, ctl_rd, lvl};
  endfunction

  function automatic logic [23:0] model_snap();
    return {m_rxi, m_txi, m_rdy, m_ovr, m_fer, m_per, m_brk, m_txe, m_tidle, m_ridle,
            m_brk, 1'b0, m_ctl, 5'(m_lvl)};
  endfunction

  function automatic int thr_of(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic model_step();
    int cap, thr, lvl_n;
    logic full, take, give, flush, clr;
    logic [6:0] ctl_n;
    cap   = m_ctl[4] ? 16 : 1;
    full  = (m_lvl == cap);
    flush = wr_ctl && (wr_data[4] != m_ctl[4]);
    give  = rd_rxd && (m_lvl != 0);
    take  = rx_done && (!full || rd_rxd);
    lvl_n = flush ? 0 : m_lvl + int'(take) - int'(give);
    ctl_n = wr_ctl ? wr_data[6:0] : m_ctl;
    thr   = ctl_n[4] ? thr_of(ctl_n[6:5]) : 1;
    clr   = wr_ctl && wr_data[7];
    m_rxi = (m_ctl[0] && (m_rdy || m_ovr || m_fer || m_per)) || (m_ctl[2] && m_brk)
          || (m_ctl[3] && (m_tidle || m_ridle));
    m_txi = m_ctl[1] && m_txe;
    m_ovr   = (rx_done && full && !rd_rxd) || (m_ovr && !clr);
    m_fer   = rx_ferr || (m_fer && !clr);
    m_per   = rx_perr || (m_per && !clr);
    m_brk   = rx_brk || (m_brk && !(wr_ctl && !wr_data[8]));
    m_txe   = tx_load || (m_txe && !wr_txd);
    m_tidle = tx_idle || (m_tidle && !tx_load);
    m_ridle = rx_idle || (m_ridle && !rx_done);
    m_rdy   = (lvl_n >= thr);
    m_lvl   = lvl_n;
    m_ctl   = ctl_n;
  endtask

  task automatic clear_inputs();
    rx_done = 0; rx_ferr = 0; rx_perr = 0; rx_brk = 0; tx_load = 0;
    rx_idle = 0; tx_idle = 0; rd_rxd = 0; wr_txd = 0; wr_ctl = 0; wr_data = '0;
  endtask

  // driver: one clock with the inputs set up beforehand
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    q_exp.push_back(model_snap());
    q_tag.push_back(tag);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic wctl(logic [8:0] d, string tag);
    wr_ctl = 1'b1;
    wr_data = d;
    cyc(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [23:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_chk++;
      if (dut_snap() !== e) begin
        n_bad++;
        $display("FAIL %s: actual %06h expected %06h", t, dut_snap(), e);
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1: actual hung expected done");
    finish_run();
  end

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (dut_snap() !== 24'h010000) begin
      n_bad++;
      $display("FAIL R1 reset: actual %06h expected %06h", dut_snap(), 24'h010000);
    end
    m_lvl = 0; m_rdy = 0; m_ovr = 0; m_fer = 0; m_per = 0; m_brk = 0; m_txe = 1;
    m_tidle = 0; m_ridle = 0; m_rxi = 0; m_txi = 0; m_ctl = '0;
    rst_n = 1'b1;
    cyc("R1");

    wctl(9'h10F, "R10");
    cyc("R7");
    rx_done = 1; cyc("R2");
    cyc("R10");
    rx_done = 1; cyc("R3");
    rx_done = 1; rd_rxd = 1; cyc("R9");
    rx_ferr = 1; cyc("R5");
    rx_perr = 1; cyc("R5");
    wctl(9'h10F, "R4");
    wctl(9'h18F, "R4");
    cyc("R4");
    rx_ferr = 1; wr_ctl = 1; wr_data = 9'h18F; cyc("R9");
    wctl(9'h18F, "R4");
    rd_rxd = 1; cyc("R2");
    rd_rxd = 1; cyc("R2");
    cyc("R10");

    rx_brk = 1; cyc("R6");
    wctl(9'h10F, "R6");
    wctl(9'h00F, "R6");
    rx_brk = 1; wr_ctl = 1; wr_data = 9'h00F; cyc("R9");
    wctl(9'h00F, "R6");

    wr_txd = 1; cyc("R7");
    cyc("R7");
    tx_load = 1; cyc("R7");
    wr_txd = 1; tx_load = 1; cyc("R9");

    rx_idle = 1; tx_idle = 1; cyc("R8");
    cyc("R8");
    wctl(9'h107, "R8");
    cyc("R8");
    wctl(9'h10F, "R8");
    rx_done = 1; cyc("R8");
    tx_load = 1; cyc("R8");
    rd_rxd = 1; cyc("R8");

    for (int s = 0; s < 4; s++) begin
      wctl(9'h11F | (9'(s) << 5), "R11");
      for (int k = 0; k < thr_of(2'(s)) + 1; k++) begin
        rx_done = 1; cyc("R2");
      end
      for (int k = 0; k < thr_of(2'(s)) + 1; k++) begin
        rd_rxd = 1; cyc("R2");
      end
      wctl(9'h10F, "R11");
    end

    wctl(9'h17F, "R11");
    for (int k = 0; k < 17; k++) begin
      rx_done = 1; cyc("R3");
    end
    rx_done = 1; rd_rxd = 1; cyc("R3");
    wctl(9'h18F, "R4");
    rx_done = 1; wr_ctl = 1; wr_data = 9'h10F; cyc("R11");
    cyc("R11");
    cyc("R10");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule